// File: doc/BRIEF.md
# Function Enable Router

This block decides, for each of a set of power-managed functions (regulators, clock buffers, a transceiver, a level shifter), whether that function is switched on. Every function carries its own 4-bit select code, which names the source of its enable: a fixed off level, a fixed on level, one bit of a small set of control registers, or one of the external multifunction input pins. Any number of functions may name the same source, so a single register write or a single pin toggle can switch a whole group.

A global sleep request drives a two-state power-mode machine. Its states are `MODE_AWAKE` and `MODE_ASLEEP`. Transition `go_sleep` leaves `MODE_AWAKE` when `sleep_req` is sampled high. Transition `wake_up` leaves `MODE_ASLEEP` when `sleep_req` is sampled low. While the machine is in `MODE_ASLEEP`, a function whose sleep-permission bit is clear is forced off. A function whose bit is set keeps following its selected source. The select codes stay as they are.

A simple write/read register port holds the control bits, the sleep-permission mask and the select codes. External pins are brought into the clock domain through a two-flop synchronizer before they are used.

Top module: `enable_router`

## Requirements
- R1: After reset, every select code, control bit and permission bit reads 0, and every `func_en` bit is 0.
- R2: Select code 4'h0 and the unused codes 4'hC to 4'hF give a disabled function in every mode.
- R3: Select code 4'h1 gives an enabled function whenever it is not gated by sleep.
- R4: Codes 4'h2 to 4'h7 pick a control bit. Code 2+2r+b selects bit b of control register r, where r is 0 to 2 at addresses 0 to 2 and b is bit 0 or 1 of the data.
- R5: Several functions holding code 4'h2 or 4'h3 are all enabled in the same cycle by one write of 2'b11 to bits [1:0] of address 0.
- R6: Codes 4'h8 to 4'hB pick pin 0 to 3. A pin level sampled at clock edge t reaches `func_en` after edge t+1.
- R7: The mode machine enters `MODE_ASLEEP` on the edge that samples `sleep_req` high and returns to `MODE_AWAKE` on the edge that samples it low. In `MODE_ASLEEP`, a function whose permission bit is 0 has `func_en` low.
- R8: A function whose permission bit is 1 follows its selected source in both modes.
- R9: The register map works as follows. Address 3 holds permission bit f at data bit f. Addresses 4 to 7 hold the select codes, with function 2k in bits [3:0] and function 2k+1 in bits [7:4] of address 4+k. Control registers hold only bits [1:0], and their upper bits read 0. Addresses 8 and above read 0, and writes to them are ignored.
- R10: A register write on a clock edge changes `func_en` in the cycle that follows that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | Global sleep request, synchronous |
| pin_in | input | 4 | Asynchronous multifunction input pins |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from address |
| func_en | output | 8 | Final enable for each function |

## Verification
On every cycle, the assertions check the source decode against the ports and the registered select state: off codes stay low, code 4'h1 stays high when not gated, sleep gating follows the sleep-permission mask, and pin-selected enables match the pin value from two edges earlier. Other behaviours can only be shown by the bench's scenarios. These are the register map and its readback, the ignoring of out-of-range writes, the group switching of many functions by one write, and write-to-output latency. The bench drives random traffic against an independent model to cover them.

// File: rtl/enable_router_pkg.sv
package enable_router_pkg;

    typedef enum logic {
        MODE_AWAKE  = 1'b0,
        MODE_ASLEEP = 1'b1
    } pm_mode_t;

    localparam logic [3:0] SEL_OFF       = 4'h0;
    localparam logic [3:0] SEL_ON        = 4'h1;
    localparam int         SEL_CTRL_BASE = 2;
    localparam int         SEL_W         = 4;

endpackage

// File: rtl/enable_regfile.sv
module enable_regfile #(
    parameter int NUM_FUNC  = 8,
    parameter int CTRL_REGS = 3,
    parameter int CTRL_BITS = 2,
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [DATA_W-1:0]             wdata,
    output logic [DATA_W-1:0]             rdata,
    output logic [CTRL_REGS*CTRL_BITS-1:0] ctrl_flat,
    output logic [NUM_FUNC-1:0]           allow,
    output logic [NUM_FUNC*4-1:0]         sel_flat
);
    localparam int CODES_PER_WORD = DATA_W / 4;
    localparam int ALLOW_ADDR     = CTRL_REGS;
    localparam int SEL_BASE       = CTRL_REGS + 1;

    logic [CTRL_REGS*CTRL_BITS-1:0] ctrl_q;
    logic [NUM_FUNC-1:0]            allow_q;
    logic [NUM_FUNC*4-1:0]          sel_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            allow_q <= '0;
            sel_q   <= '0;
        end else if (we) begin
            for (int r = 0; r < CTRL_REGS; r++) begin
                if (addr == ADDR_W'(r))
                    ctrl_q[r*CTRL_BITS +: CTRL_BITS] <= wdata[CTRL_BITS-1:0];
            end
            if (addr == ADDR_W'(ALLOW_ADDR))
                allow_q <= wdata[NUM_FUNC-1:0];
            for (int f = 0; f < NUM_FUNC; f++) begin
                if (addr == ADDR_W'(SEL_BASE + f / CODES_PER_WORD))
                    sel_q[f*4 +: 4] <= wdata[(f % CODES_PER_WORD)*4 +: 4];
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int r = 0; r < CTRL_REGS; r++) begin
            if (addr == ADDR_W'(r))
                rdata[CTRL_BITS-1:0] = ctrl_q[r*CTRL_BITS +: CTRL_BITS];
        end
        if (addr == ADDR_W'(ALLOW_ADDR))
            rdata[NUM_FUNC-1:0] = allow_q;
        for (int f = 0; f < NUM_FUNC; f++) begin
            if (addr == ADDR_W'(SEL_BASE + f / CODES_PER_WORD))
                rdata[(f % CODES_PER_WORD)*4 +: 4] = sel_q[f*4 +: 4];
        end
    end

    assign ctrl_flat = ctrl_q;
    assign allow     = allow_q;
    assign sel_flat  = sel_q;

endmodule

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;

endmodule

// File: rtl/enable_select.sv
module enable_select
    import enable_router_pkg::*;
#(
    parameter int CTRL_W   = 6,
    parameter int NUM_PINS = 4
) (
    input  logic [3:0]          code,
    input  logic [CTRL_W-1:0]   ctrl_flat,
    input  logic [NUM_PINS-1:0] pin_s,
    output logic                src_en
);
    localparam int PIN_BASE = SEL_CTRL_BASE + CTRL_W;

    always_comb begin
        src_en = 1'b0;
        if (code == SEL_ON)
            src_en = 1'b1;
        for (int k = 0; k < CTRL_W; k++) begin
            if (code == 4'(SEL_CTRL_BASE + k))
                src_en = ctrl_flat[k];
        end
        for (int p = 0; p < NUM_PINS; p++) begin
            if (code == 4'(PIN_BASE + p))
                src_en = pin_s[p];
        end
    end

endmodule

// File: rtl/enable_router.sv
module enable_router
    import enable_router_pkg::*;
#(
    parameter int NUM_FUNC  = 8,
    parameter int NUM_PINS  = 4,
    parameter int CTRL_REGS = 3,
    parameter int CTRL_BITS = 2,
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sleep_req,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic                reg_we,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic [NUM_FUNC-1:0] func_en
);
    localparam int CTRL_W = CTRL_REGS * CTRL_BITS;

    logic [CTRL_W-1:0]     ctrl_flat;
    logic [NUM_FUNC-1:0]   allow_q;
    logic [NUM_FUNC*4-1:0] sel_flat;
    logic [NUM_PINS-1:0]   pin_s;
    logic [NUM_FUNC-1:0]   src_en;

    pm_mode_t state_q, state_d;

    enable_regfile #(
        .NUM_FUNC (NUM_FUNC),
        .CTRL_REGS(CTRL_REGS),
        .CTRL_BITS(CTRL_BITS),
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .ctrl_flat(ctrl_flat),
        .allow    (allow_q),
        .sel_flat (sel_flat)
    );

    pin_sync #(.WIDTH(NUM_PINS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in(pin_in),
        .sync_out(pin_s)
    );

    for (genvar f = 0; f < NUM_FUNC; f++) begin : g_func
        enable_select #(
            .CTRL_W  (CTRL_W),
            .NUM_PINS(NUM_PINS)
        ) u_sel (
            .code     (sel_flat[f*4 +: 4]),
            .ctrl_flat(ctrl_flat),
            .pin_s    (pin_s),
            .src_en   (src_en[f])
        );
    end

    // Power-mode state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_AWAKE;
        else        state_q <= state_d;
    end

    // Transitions: go_sleep and wake_up
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_AWAKE:  if (sleep_req)  state_d = MODE_ASLEEP;
            MODE_ASLEEP: if (!sleep_req) state_d = MODE_AWAKE;
        endcase
    end

    // Outputs: sleep gating per function
    always_comb begin
        func_en = '0;
        unique case (state_q)
            MODE_AWAKE:  func_en = src_en;
            MODE_ASLEEP: func_en = src_en & allow_q;
        endcase
    end

endmodule

// File: rtl/enable_router_chk.sv
module enable_router_chk #(
    parameter int NUM_FUNC  = 8,
    parameter int NUM_PINS  = 4,
    parameter int CTRL_REGS = 3,
    parameter int CTRL_BITS = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  sleep_req,
    input logic [NUM_PINS-1:0]   pin_in,
    input logic [NUM_FUNC-1:0]   func_en,
    input logic [NUM_FUNC*4-1:0] sel_flat,
    input logic [NUM_FUNC-1:0]   allow
);
    localparam int PIN_BASE = 2 + CTRL_REGS * CTRL_BITS;

    logic [1:0] since_rst;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |-> func_en == '0);

    for (genvar f = 0; f < NUM_FUNC; f++) begin : g_f
        assert_off_codes_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_flat[f*4 +: 4] == 4'h0 || sel_flat[f*4 +: 4] >= 4'hC) |-> !func_en[f]);

        assert_always_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (since_rst != 2'd0 && sel_flat[f*4 +: 4] == 4'h1 && !$past(sleep_req))
            |-> func_en[f]);

        assert_sleep_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (since_rst != 2'd0 && $past(sleep_req) && !allow[f]) |-> !func_en[f]);

        assert_allow_passes_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (since_rst != 2'd0 && $past(sleep_req) && allow[f] && sel_flat[f*4 +: 4] == 4'h1)
            |-> func_en[f]);

        for (genvar p = 0; p < NUM_PINS; p++) begin : g_p
            assert_pin_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (since_rst == 2'd3 && sel_flat[f*4 +: 4] == 4'(PIN_BASE + p)
                 && (allow[f] || !$past(sleep_req)))
                |-> func_en[f] == $past(pin_in[p], 2));
        end
    end

endmodule

bind enable_router enable_router_chk #(
    .NUM_FUNC (NUM_FUNC),
    .NUM_PINS (NUM_PINS),
    .CTRL_REGS(CTRL_REGS),
    .CTRL_BITS(CTRL_BITS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sleep_req(sleep_req),
    .pin_in   (pin_in),
    .func_en  (func_en),
    .sel_flat (sel_flat),
    .allow    (allow_q)
);

// File: tb/enable_router_test.sv
module enable_router_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sleep_req = 1'b0;
    logic [3:0] pin_in = '0;
    logic       reg_we = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [7:0] func_en;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // independent model state
    logic [5:0]  ctrl_m  = '0;
    logic [7:0]  allow_m = '0;
    logic [31:0] sel_m   = '0;
    logic        asleep_m = 1'b0;
    logic [3:0]  s1_m = '0, s2_m = '0;

    enable_router uut (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .pin_in(pin_in),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .func_en(func_en)
    );

    always #10 clk = ~clk;

    function automatic logic [7:0] exp_en();
        logic [7:0] e = '0;
        for (int f = 0; f < 8; f++) begin
            int c = int'(sel_m[f*4 +: 4]);
            logic s = 1'b0;
            if (c == 1) s = 1'b1;
            else if (c >= 2 && c <= 7) s = ctrl_m[c-2];
            else if (c >= 8 && c <= 11) s = s2_m[c-8];
            if (asleep_m && !allow_m[f]) s = 1'b0;
            e[f] = s;
        end
        return e;
    endfunction

    function automatic logic [7:0] exp_rd(int a);
        if (a <= 2) return {6'b0, ctrl_m[a*2 +: 2]};
        if (a == 3) return allow_m;
        if (a <= 7) return sel_m[(a-4)*8 +: 8];
        return 8'h00;
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one clock: model follows the edge, returns at the falling edge
    task automatic tick();
        @(posedge clk);
        if (reg_we) begin
            int a = int'(reg_addr);
            if (a <= 2) ctrl_m[a*2 +: 2] = reg_wdata[1:0];
            else if (a == 3) allow_m = reg_wdata;
            else if (a <= 7) sel_m[(a-4)*8 +: 8] = reg_wdata;
        end
        asleep_m = sleep_req;
        s2_m = s1_m;
        s1_m = pin_in;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic wr(int a, logic [7:0] d);
        reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = d;
        tick();
    endtask

    task automatic rd_check(string req, int a);
        reg_addr = 4'(a);
        #1;
        check(req, reg_rdata, exp_rd(a));
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R1 reset en", func_en, 8'h00);
        rst_n = 1'b1;
        tick();
        for (int a = 0; a < 8; a++) rd_check("R1 reset reg", a);
        check("R1 en after reset", func_en, 8'h00);

        // R3 / R10: all code 1, output on right after the write edge
        wr(4, 8'h11); wr(5, 8'h11); wr(6, 8'h11);
        check("R10 partial group", func_en, 8'h3F);
        wr(7, 8'h11);
        check("R3 always on", func_en, 8'hFF);

        // R7 / R8: sleep gating with mixed mask
        wr(3, 8'h0F);
        sleep_req = 1'b1;
        tick();
        check("R7 R8 asleep", func_en, 8'h0F);
        sleep_req = 1'b0;
        tick();
        check("R7 wake_up", func_en, 8'hFF);

        // R5: group of four on code 2 switched by one write
        wr(0, 8'h00);
        wr(4, 8'h22); wr(5, 8'h22);
        check("R5 group off", func_en, 8'hF0);
        wr(0, 8'h03);
        check("R5 group on", func_en, 8'hFF);

        // R4: code 7 picks ctrl reg 2 bit 1
        wr(6, 8'h77);
        check("R4 ctrl2b1 low", func_en, 8'hCF);
        wr(2, 8'h02);
        check("R4 ctrl2b1 high", func_en, 8'hFF);

        // R2: unused and off codes
        wr(7, 8'hC0);
        check("R2 off codes", func_en, 8'h3F);
        wr(7, 8'hFE);
        check("R2 code F and E", func_en, 8'h3F);

        // R6: pin 1 through two edges
        wr(4, 8'h99);
        pin_in = 4'b0010;
        tick();
        check("R6 one edge", func_en[1:0], 2'b00);
        tick();
        check("R6 two edges", func_en[1:0], 2'b11);

        // R9: out-of-range writes ignored, upper ctrl bits read zero
        wr(9, 8'hFF);
        rd_check("R9 addr 9", 9);
        wr(1, 8'hFF);
        rd_check("R9 ctrl upper", 1);
        check("R9 en after ignored write", func_en, exp_en());

        // random traffic against the model
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 2) == 0) begin
                reg_we = 1'b1;
                reg_addr = 4'($urandom_range(0, 9));
                reg_wdata = 8'($urandom);
            end
            if ($urandom_range(0, 7) == 0) sleep_req = ~sleep_req;
            if ($urandom_range(0, 3) == 0) pin_in = 4'($urandom);
            tick();
            check("R4 R6 R7 R8 random en", func_en, exp_en());
            rd_check("R9 random read", $urandom_range(0, 9));
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule